// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block lets a host drive an external three-wire serial EEPROM through two registers. The command register holds a start/busy flag, a three-bit operation code and a byte address. The data register holds the byte to program or the byte last read. When the host sets the start flag, the controller builds the serial frame and clocks it out on chip select, serial clock and serial data lines. For program and erase operations it then waits for the device's ready indication. When the operation completes it drops the busy flag by itself.

After reset the controller reads seven bytes from EEPROM addresses 0 to 6 without any host action. A correct tag byte at address 0 makes the following six bytes the station address that other logic consumes. Busy stays high from reset until this load finishes or is abandoned. When no device is fitted, a bounded wait clears busy after a program operation and records a timeout flag. The serial clock half-period `SK_HALF` must be at least 2 system clocks.

Top module: `eectl_top`

## Requirements
- R1: Busy (command register bit 31, offset 0xB0) reads 1 from reset until the station-address load ends, and host writes during that time change nothing.
- R2: The load reads addresses 0..6; if address 0 holds 0xA5, the valid flag (command bit 8) becomes 1 and `station_addr` holds bytes 1..6 with byte 1 in bits 7:0; any other tag leaves the valid flag at 0.
- R3: Writing the command register with bit 31 = 1 while idle starts the operation in bits 30:28 (0 READ, 1 write-disable, 2 write-enable, 3 WRITE, 4 write-all, 5 ERASE, 6 erase-all, 7 RELOAD) at the address in bits 7:0, and busy reads 1 on the next cycle.
- R4: Writing the command register with bit 31 = 0 starts nothing: busy stays 0 and chip select stays low.
- R5: While busy, writes to the command register and to the data register (offset 0xB4, bits 7:0) are ignored.
- R6: After a READ, the data register holds the addressed EEPROM byte once busy has cleared.
- R7: Each frame is a 1 start bit, a 2-bit opcode (10 read, 01 write, 11 erase, 00 extended) and 8 address bits, MSB first; write and write-all append the data byte; the extended forms use address bits 7:6 = 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R8: After a program or erase frame, the controller drops chip select for at least one serial period, raises it again and holds busy until serial data-out reads 1.
- R9: If data-out stays 0 for `TIMEOUT_CYC` system clocks of that wait, busy clears and the timeout flag (command bit 9) is set; writing 1 to bit 9 while idle clears it.
- R10: Chip select stays low for at least 2*`SK_HALF` system clocks between any two assertions.
- R11: The serial clock has a period of 2*`SK_HALF` system clocks, is high only while chip select is high, and serial data-in changes only while the serial clock is low.
- R12: RELOAD repeats the station-address load, with busy held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset (0xB0 command, 0xB4 data) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| station_addr | output | 48 | Loaded station address |
| station_valid | output | 1 | Station address was read with a correct tag |

## Verification
Assertions check on every cycle that chip select is low while busy is clear, that the low gap before each chip select rises lasts at least one serial period, that data-in holds steady while the serial clock is high, that the command fields and data byte stay frozen while busy, and that the timeout flag rises only when the engine reports an expired wait. The content of the frames, the read data and the result of program operations can only be shown by the bench's scenarios against its behavioural EEPROM model. The same holds for the tag decision of the load, for RELOAD, for the timeout length with no device fitted and for the W1C clear.

// File: rtl/eectl_pkg.sv
`timescale 1ns/1ps
package eectl_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int BITS_W  = $clog2(FRAME_W + DATA_W + 1);
    localparam int STATION_BYTES = 6;
    localparam logic [7:0] STATION_TAG = 8'hA5;
    localparam logic [7:0] CMD_OFS  = 8'hB0;
    localparam logic [7:0] DATA_OFS = 8'hB4;
    localparam int TMO_BIT = 9;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_EWDS   = 3'd1,
        OP_EWEN   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_WRAL   = 3'd4,
        OP_ERASE  = 3'd5,
        OP_ERAL   = 3'd6,
        OP_RELOAD = 3'd7
    } host_op_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // left aligned, sent MSB first
        logic [BITS_W-1:0]  n_out;  // bits driven onto data-in
        logic               rd;     // clock in one data byte afterwards
        logic               wt;     // poll ready after the frame
    } frame_t;

    function automatic frame_t build_frame(input host_op_e op,
                                           input logic [ADDR_W-1:0] a,
                                           input logic [DATA_W-1:0] d);
        frame_t f;
        f.bits  = '0;
        f.n_out = BITS_W'(3 + ADDR_W);
        f.rd    = 1'b0;
        f.wt    = 1'b0;
        unique case (op)
            OP_EWDS:  f.bits = {3'b100, 8'h00, 8'h00};
            OP_EWEN:  f.bits = {3'b100, 8'hC0, 8'h00};
            OP_WRITE: begin
                f.bits  = {3'b101, a, d};
                f.n_out = BITS_W'(FRAME_W);
                f.wt    = 1'b1;
            end
            OP_WRAL: begin
                f.bits  = {3'b100, 8'h40, d};
                f.n_out = BITS_W'(FRAME_W);
                f.wt    = 1'b1;
            end
            OP_ERASE: begin
                f.bits = {3'b111, a, 8'h00};
                f.wt   = 1'b1;
            end
            OP_ERAL: begin
                f.bits = {3'b100, 8'h80, 8'h00};
                f.wt   = 1'b1;
            end
            default: begin
                f.bits = {3'b110, a, 8'h00};
                f.rd   = 1'b1;
            end
        endcase
        return f;
    endfunction
endpackage

// File: rtl/eectl_timer.sv
`timescale 1ns/1ps
module eectl_timer #(
    parameter int LIMIT = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)
            cnt_d = '0;
        else if (cnt_q == CW'(LIMIT - 1))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/eectl_serial.sv
`timescale 1ns/1ps
module eectl_serial
    import eectl_pkg::*;
#(
    parameter int SK_HALF     = 4,
    parameter int TIMEOUT_CYC = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  frame_t            frm_in,
    input  logic              ee_do,
    output logic              done,
    output logic              tmo,
    output logic [DATA_W-1:0] rx,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di
);
    localparam int PER   = 2 * SK_HALF;
    localparam int DIV_W = $clog2(PER);

    typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP, E_POLL} eng_st_e;

    typedef struct packed {
        eng_st_e           st;
        logic [DIV_W-1:0]  div;
        logic [BITS_W-1:0] bit_i;
        frame_t            frm;
        logic              polled;
        logic [DATA_W-1:0] rx;
        logic              tmo;
        logic              done;
        logic              cs;
        logic              sk;
        logic              di;
    } eng_s;

    eng_s q, n;
    logic expired;
    logic [BITS_W-1:0]  last_bit;
    logic [FRAME_W-1:0] sh_v;

    eectl_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.st == E_POLL),
        .expired (expired)
    );

    assign last_bit = q.frm.n_out + (q.frm.rd ? BITS_W'(DATA_W) : BITS_W'(0)) - 1'b1;

    always_comb begin
        n = q;
        n.done = 1'b0;
        unique case (q.st)
            E_IDLE: if (start) begin
                n.st     = E_SHIFT;
                n.frm    = frm_in;
                n.div    = '0;
                n.bit_i  = '0;
                n.polled = 1'b0;
                n.tmo    = 1'b0;
            end
            E_SHIFT: begin
                if (q.div == DIV_W'(PER - 1)) begin
                    n.div = '0;
                    if (q.bit_i >= q.frm.n_out)
                        n.rx = {q.rx[DATA_W-2:0], ee_do};
                    if (q.bit_i == last_bit) n.st = E_GAP;
                    else                     n.bit_i = q.bit_i + 1'b1;
                end else begin
                    n.div = q.div + 1'b1;
                end
            end
            E_GAP: begin
                if (q.div == DIV_W'(PER - 1)) begin
                    n.div = '0;
                    if (q.frm.wt && !q.polled) begin
                        n.st = E_POLL;
                    end else begin
                        n.st   = E_IDLE;
                        n.done = 1'b1;
                    end
                end else begin
                    n.div = q.div + 1'b1;
                end
            end
            E_POLL: begin
                if (ee_do) begin
                    n.polled = 1'b1;
                    n.st     = E_GAP;
                end else if (expired) begin
                    n.tmo    = 1'b1;
                    n.polled = 1'b1;
                    n.st     = E_GAP;
                end
            end
            default: n.st = E_IDLE;
        endcase
        sh_v = n.frm.bits << n.bit_i;
        n.cs = (n.st == E_SHIFT) || (n.st == E_POLL);
        n.sk = (n.st == E_SHIFT) && (n.div >= DIV_W'(SK_HALF));
        n.di = (n.st == E_SHIFT) && (n.bit_i < n.frm.n_out) && sh_v[FRAME_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done  = q.done;
    assign tmo   = q.tmo;
    assign rx    = q.rx;
    assign ee_cs = q.cs;
    assign ee_sk = q.sk;
    assign ee_di = q.di;

    // checker state: cycles chip select has been low, saturating
    logic [DIV_W:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      gap_q <= (DIV_W+1)'(PER);
        else if (q.cs)                   gap_q <= '0;
        else if (gap_q < (DIV_W+1)'(PER)) gap_q <= gap_q + 1'b1;
    end

    a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs) |-> (gap_q >= (DIV_W+1)'(PER)));

    a_r11_di_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sk && $past(q.sk)) |-> $stable(q.di));

    a_r11_sk_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        q.sk |-> q.cs);

    a_r9_tmo_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tmo) |-> ($past(q.st) == E_POLL));
endmodule

// File: rtl/eectl_seq.sv
`timescale 1ns/1ps
module eectl_seq
    import eectl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 reg_addr,
    input  logic                       reg_we,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic                       eng_done,
    input  logic                       eng_tmo,
    input  logic [DATA_W-1:0]          eng_rx,
    output logic                       eng_start,
    output frame_t                     eng_frm,
    output logic                       busy,
    output logic [8*STATION_BYTES-1:0] station_addr,
    output logic                       station_valid
);
    localparam int IDX_W = $clog2(STATION_BYTES + 1);

    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_CMD} seq_st_e;

    typedef struct packed {
        seq_st_e                  st;
        logic                     busy;
        host_op_e                 op;
        logic [ADDR_W-1:0]        addr;
        logic [DATA_W-1:0]        data;
        logic                     tmo;
        logic                     valid;
        logic [8*STATION_BYTES-1:0] mac;
        logic [IDX_W-1:0]         idx;
        logic                     issue;
    } seq_s;

    seq_s q, n;
    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[27:10], reg_wdata[8]};

    always_comb begin
        n = q;
        n.issue = 1'b0;
        unique case (q.st)
            S_IDLE: if (reg_we) begin
                if (reg_addr == CMD_OFS) begin
                    if (reg_wdata[TMO_BIT]) n.tmo = 1'b0;
                    if (reg_wdata[31]) begin
                        n.op    = host_op_e'(reg_wdata[30:28]);
                        n.addr  = reg_wdata[ADDR_W-1:0];
                        n.busy  = 1'b1;
                        n.issue = 1'b1;
                        if (n.op == OP_RELOAD) begin
                            n.st    = S_LOAD;
                            n.idx   = '0;
                            n.valid = 1'b0;
                        end else begin
                            n.st = S_CMD;
                        end
                    end
                end else if (reg_addr == DATA_OFS) begin
                    n.data = reg_wdata[DATA_W-1:0];
                end
            end
            S_LOAD: if (eng_done) begin
                if (q.idx == '0 && eng_rx != STATION_TAG) begin
                    n.st   = S_IDLE;
                    n.busy = 1'b0;
                end else begin
                    for (int b = 0; b < STATION_BYTES; b++)
                        if (q.idx == IDX_W'(b + 1)) n.mac[b*8 +: 8] = eng_rx;
                    if (q.idx == IDX_W'(STATION_BYTES)) begin
                        n.valid = 1'b1;
                        n.busy  = 1'b0;
                        n.st    = S_IDLE;
                    end else begin
                        n.idx   = q.idx + 1'b1;
                        n.issue = 1'b1;
                    end
                end
            end
            S_CMD: if (eng_done) begin
                if (q.op == OP_READ) n.data = eng_rx;
                if (eng_tmo)         n.tmo  = 1'b1;
                n.busy = 1'b0;
                n.st   = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_LOAD;
            q.busy  <= 1'b1;
            q.issue <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign eng_start = q.issue;
    assign eng_frm   = (q.st == S_LOAD)
                     ? build_frame(OP_READ, ADDR_W'(q.idx), '0)
                     : build_frame(q.op, q.addr, q.data);
    assign busy          = q.busy;
    assign station_addr  = q.mac;
    assign station_valid = q.valid;

    always_comb begin
        unique case (reg_addr)
            CMD_OFS:  reg_rdata = {q.busy, q.op, 18'd0, q.tmo, q.valid, q.addr};
            DATA_OFS: reg_rdata = {24'd0, q.data};
            default:  reg_rdata = '0;
        endcase
    end

    a_r5_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.busy) |-> ($stable(q.op) && $stable(q.addr)));

    a_r5_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.busy) && !$past(eng_done)) |-> $stable(q.data));

    a_r9_tmo_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tmo) |-> $past(eng_done && eng_tmo));
endmodule

// File: rtl/eectl_top.sv
`timescale 1ns/1ps
module eectl_top
    import eectl_pkg::*;
#(
    parameter int SK_HALF     = 4,
    parameter int TIMEOUT_CYC = 30000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do,
    output logic [47:0] station_addr,
    output logic        station_valid
);
    logic              eng_start, eng_done, eng_tmo, busy;
    logic [DATA_W-1:0] eng_rx;
    frame_t            eng_frm;

    eectl_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_we        (reg_we),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .eng_done      (eng_done),
        .eng_tmo       (eng_tmo),
        .eng_rx        (eng_rx),
        .eng_start     (eng_start),
        .eng_frm       (eng_frm),
        .busy          (busy),
        .station_addr  (station_addr),
        .station_valid (station_valid)
    );

    eectl_serial #(.SK_HALF(SK_HALF), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .frm_in (eng_frm),
        .ee_do  (ee_do),
        .done   (eng_done),
        .tmo    (eng_tmo),
        .rx     (eng_rx),
        .ee_cs  (ee_cs),
        .ee_sk  (ee_sk),
        .ee_di  (ee_di)
    );

    a_r8_idle_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_cs);

    a_r2_valid_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(station_valid));
endmodule

// File: tb/eectl_top_test.sv
`timescale 1ns/1ps
module eectl_top_test;
    localparam int SK_HALF = 4;
    localparam int TMO     = 30000;
    localparam logic [7:0] CMD = 8'hB0;
    localparam logic [7:0] DAT = 8'hB4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  reg_addr = CMD;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic ee_cs, ee_sk, ee_di, ee_do;
    logic [47:0] station_addr;
    logic station_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    eectl_top #(.SK_HALF(SK_HALF), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .station_addr(station_addr), .station_valid(station_valid)
    );

    // ---------------- behavioural serial EEPROM ----------------
    logic [7:0] mem [256];
    bit   present = 1'b1;
    bit   wen = 1'b0;
    int   cnt = 0;
    logic [18:0] sh = '0;
    logic [7:0] rbyte = '0;
    int   oi = 0;
    int   pk = 0;
    logic [7:0] pa = '0, pd = '0;
    logic sk_p = 1'b0, cs_p = 1'b0;
    logic do_r = 1'b0;
    logic reading = 1'b0;
    int   busy_cnt = 0;

    assign ee_do = present && ee_cs && (reading ? do_r : (busy_cnt == 0));

    always @(posedge clk) begin
        int bc;
        bit rd_m;
        bc   = (busy_cnt > 0) ? busy_cnt - 1 : 0;
        rd_m = reading;
        if (cs_p && !ee_cs) begin
            if (wen && pk != 0) begin
                for (int i = 0; i < 256; i++) begin
                    if (pk == 2) mem[i] = pd;
                    if (pk == 4) mem[i] = 8'hFF;
                end
                if (pk == 1) mem[pa] = pd;
                if (pk == 3) mem[pa] = 8'hFF;
                bc = 40;
            end
            pk = 0; cnt = 0; sh = '0; rd_m = 1'b0;
        end else if (ee_cs && ee_sk && !sk_p && present) begin
            if (rd_m) begin
                do_r <= rbyte[7-oi];
                oi++;
            end else begin
                sh = {sh[17:0], ee_di};
                cnt++;
                if (cnt == 11) begin
                    case (sh[9:8])
                        2'b10: begin rd_m = 1'b1; rbyte = mem[sh[7:0]]; oi = 0; do_r <= 1'b0; end
                        2'b11: begin pk = 3; pa = sh[7:0]; end
                        2'b00: case (sh[7:6])
                            2'b11: wen = 1'b1;
                            2'b00: wen = 1'b0;
                            2'b10: pk = 4;
                            default: ;
                        endcase
                        default: ;
                    endcase
                end
                if (cnt == 19) begin
                    if (sh[17:16] == 2'b01) begin pk = 1; pa = sh[15:8]; pd = sh[7:0]; end
                    if (sh[17:16] == 2'b00 && sh[15:14] == 2'b01) begin pk = 2; pd = sh[7:0]; end
                end
            end
        end
        sk_p = ee_sk;
        cs_p = ee_cs;
        reading  <= rd_m;
        busy_cnt <= bc;
    end

    // ---------------- checks ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // per-clock monitors: chip-select gap (R10) and data-in stability (R11)
    int  low_run = 1000;
    logic sk_m = 1'b0, di_m = 1'b0, cs_m = 1'b0;
    bit  di_moved = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            low_run = 1000;
        end else begin
            if (ee_cs && !cs_m) chk("R10 cs low gap >= period", low_run >= 2*SK_HALF, 1);
            low_run = ee_cs ? 0 : low_run + 1;
            if (ee_sk && !ee_cs) chk("R11 sk only with cs", 0, 1);
            if (ee_sk && sk_m && ee_di !== di_m) di_moved = 1'b1;
            if (!ee_sk && sk_m) begin
                chk("R11 di steady while sk high", di_moved, 0);
                di_moved = 1'b0;
            end
        end
        sk_m = ee_sk; di_m = ee_di; cs_m = ee_cs;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    // ---------------- host tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = CMD;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = CMD;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] a);
        wr(CMD, {1'b1, op, 20'd0, a});
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] v;
        cyc = 0;
        forever begin
            @(negedge clk);
            rd(CMD, v);
            if (!v[31]) break;
            cyc++;
        end
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] b);
        int c;
        logic [31:0] v;
        cmd(3'd0, a);
        wait_idle(c);
        rd(DAT, v);
        b = v[7:0];
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        int c;
        bit cs_seen;
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        mem[0] = 8'hA5;
        for (int i = 1; i <= 6; i++) mem[i] = 8'(i * 8'h11);

        do_reset();
        @(negedge clk);
        rd(CMD, v);
        chk("R1 busy after reset", v[31], 1);
        wr(DAT, 32'hEE);
        wait_idle(c);
        rd(DAT, v);
        chk("R1 data write during load ignored", v[7:0], 8'h00);
        rd(CMD, v);
        chk("R2 valid after good tag", v[8], 1);
        chk("R2 station address", station_addr, 48'h665544332211);

        // R4: bit 31 clear starts nothing
        wr(CMD, 32'h0000_0012);
        cs_seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ee_cs) cs_seen = 1'b1;
        end
        rd(CMD, v);
        chk("R4 no busy", v[31], 0);
        chk("R4 no chip select", cs_seen, 0);

        // R3, R5, R6
        cmd(3'd0, 8'h03);
        rd(CMD, v);
        chk("R3 busy next cycle", v[31], 1);
        chk("R3 fields latched", {v[30:28], v[7:0]}, {3'd0, 8'h03});
        wr(DAT, 32'hEE);
        cmd(3'd0, 8'h05);
        wait_idle(c);
        rd(DAT, v);
        chk("R6 read data", v[7:0], 8'h33);
        rd(CMD, v);
        chk("R5 address unchanged by busy write", v[7:0], 8'h03);

        // R7, R8: program operations
        cmd(3'd2, 8'h00);
        wait_idle(c);
        wr(DAT, 32'h5A);
        cmd(3'd3, 8'h20);
        wait_idle(c);
        chk("R8 busy covers frame and ready wait", c > 190, 1);
        rd(CMD, v);
        chk("R8 no timeout with device", v[9], 0);
        read_byte(8'h20, b);
        chk("R7 write then read", b, 8'h5A);
        cmd(3'd5, 8'h20);
        wait_idle(c);
        read_byte(8'h20, b);
        chk("R7 erase", b, 8'hFF);
        wr(DAT, 32'h77);
        cmd(3'd4, 8'h00);
        wait_idle(c);
        read_byte(8'h99, b);
        chk("R7 write all", b, 8'h77);
        cmd(3'd6, 8'h00);
        wait_idle(c);
        read_byte(8'h99, b);
        chk("R7 erase all", b, 8'hFF);
        cmd(3'd1, 8'h00);
        wait_idle(c);
        wr(DAT, 32'h12);
        cmd(3'd3, 8'h10);
        wait_idle(c);
        read_byte(8'h10, b);
        chk("R7 write disabled", b, 8'hFF);

        // R12: reload
        mem[0] = 8'hA5;
        for (int i = 1; i <= 6; i++) mem[i] = 8'(i);
        cmd(3'd7, 8'h00);
        rd(CMD, v);
        chk("R12 busy during reload", v[31], 1);
        wait_idle(c);
        rd(CMD, v);
        chk("R12 valid after reload", v[8], 1);
        chk("R12 new station address", station_addr, 48'h060504030201);
        mem[0] = 8'h00;
        cmd(3'd7, 8'h00);
        wait_idle(c);
        rd(CMD, v);
        chk("R2 bad tag clears valid", v[8], 0);

        // R9: no device
        present = 1'b0;
        cmd(3'd3, 8'h30);
        wait_idle(c);
        chk("R9 busy held for timeout", c >= TMO, 1);
        rd(CMD, v);
        chk("R9 timeout flag set", v[9], 1);
        wr(CMD, 32'h0000_0200);
        rd(CMD, v);
        chk("R9 timeout flag cleared", v[9], 0);

        // R1/R2: reset with no device
        do_reset();
        @(negedge clk);
        rd(CMD, v);
        chk("R1 busy after reset, no device", v[31], 1);
        wait_idle(c);
        rd(CMD, v);
        chk("R2 no device leaves invalid", v[8], 0);

        repeat (5) @(negedge clk);
        report();
    end
endmodule